// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Controller

This block is the central scheduling controller for a small floating-point pipeline. It has five execution resources: one integer/load unit, two multipliers, one adder and one divider. Decoded instructions arrive in program order. Each carries an operation class, a destination register and two source register numbers. The controller issues them strictly in order. It then lets each one fetch its operands and start executing as soon as its own inputs are ready, even ahead of older instructions. Finally it grants the result write, one unit per cycle.

Each unit's arithmetic is modelled only as a latency countdown. The controller tracks three things: the stage each instruction has reached, a status entry per unit, and an owner code per register. The owner code names the unit that will write that register next. Every stage event appears on the ports as a per-unit strobe, together with a free-running cycle number and each unit's instruction tag. An environment can therefore rebuild the full issue/read/complete/write schedule of a program.

Top module: `sb_scoreboard_ctrl`

## Requirements
- R1: An instruction is accepted (`in_ready` high with `in_valid`) only when a unit of its class is idle and no in-flight instruction owns its destination. While it waits, nothing behind it is accepted. An idle unit is first seen as free in the cycle after its write.
- R2: An instruction reads its operands no earlier than the cycle after its issue. It reads in the first cycle in which neither source still awaits a pending producer.
- R3: No two in-flight instructions share a destination register. An instruction whose destination is owned issues no earlier than the cycle after that owner's write.
- R4: On issue, the destination's owner code becomes the chosen unit's code (unit index plus one; 0 means no pending writer). On write, the code returns to 0. If a source's producer writes in the same cycle as the issue, that source counts as already available.
- R5: Execution completes exactly L cycles after the operand read, where L is 1 for class 0 (integer/load), 10 for class 1 (multiply), 2 for class 2 (add/subtract) and 40 for class 3 (divide).
- R6: A result is written no earlier than the cycle after completion. The write is held while any older instruction that names the destination as a source has not yet read its operands.
- R7: A write marks that register ready for every waiting unit that expects it. Those units may read in the following cycle, several of them in the same cycle.
- R8: At most one unit writes per cycle. When several could write, the lowest unit index wins. Unit indices are 0 integer, 1..2 multipliers, 3 adder, 4 divider.
- R9: Class 1 goes to the lowest-numbered idle multiplier. Tags are assigned 0, 1, 2, ... in issue order, modulo 16.
- R10: During and right after reset no unit is busy, all strobes are low, `in_ready` is high and the cycle number reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_op | input | 2 | Operation class: 0 integer/load, 1 multiply, 2 add/subtract, 3 divide |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| in_ready | output | 1 | Offered instruction is accepted this cycle |
| iss_fire | output | 1 | Issue event this cycle |
| iss_tag | output | 4 | Tag given to the issued instruction |
| cycle_no | output | 16 | Current cycle number, 1 in the first cycle after reset |
| rd_fire | output | 5 | Per-unit operand-read event |
| done_fire | output | 5 | Per-unit execution-complete event |
| wb_fire | output | 5 | Per-unit write-result grant (at most one set) |
| unit_tags | output | 20 | Tag of each unit's current instruction, 4 bits per unit |

## Verification
The bench uses the default parameters: two multipliers, sixteen registers, 4-bit tags and latencies 1/10/2/40. With these values the classic six-instruction load/multiply/subtract/divide/add program can be checked cycle by cycle. That program includes the add that is held at write by the divider's unread source. Random programs then draw on only eight registers, so RAW, WAR and WAW conflicts are frequent. With both multipliers present, out-of-order completion among equal-latency units can also occur. Directed cases pin down the same-cycle write priority, the wake-up of a source at issue, and a destination stall behind a 40-cycle divide.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    OPC_INT = 2'd0,
    OPC_MUL = 2'd1,
    OPC_ADD = 2'd2,
    OPC_DIV = 2'd3
  } opclass_e;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAIT_OPS = 2'd1,
    PH_EXEC     = 2'd2,
    PH_WAIT_WB  = 2'd3
  } phase_e;

  // latency of unit index u: 0 integer, 1..nmul multipliers, then adder, divider
  function automatic int unit_latency(int u, int nmul, int li, int lm, int la, int ld);
    if (u == 0) return li;
    if (u <= nmul) return lm;
    if (u == nmul + 1) return la;
    return ld;
  endfunction

  // counter width able to hold the largest latency
  function automatic int lat_bits(int li, int lm, int la, int ld);
    int m;
    m = li;
    if (lm > m) m = lm;
    if (la > m) m = la;
    if (ld > m) m = ld;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int N  = 5,
  parameter int CW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [CW-1:0] code
);
  // fixed priority: lowest index wins
  always_comb begin
    grant = '0;
    code  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        code     = CW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
  import sb_pkg::*;
#(
  parameter int RW      = 4,
  parameter int UCW     = 3,
  parameter int TAGW    = 4,
  parameter int LATW    = 6,
  parameter int LATENCY = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_en,
  input  logic [RW-1:0]   iss_dst,
  input  logic [RW-1:0]   iss_src1,
  input  logic [RW-1:0]   iss_src2,
  input  logic [UCW-1:0]  iss_q1,
  input  logic [UCW-1:0]  iss_q2,
  input  logic [TAGW-1:0] iss_tag,
  input  logic            wb_any,
  input  logic [UCW-1:0]  wb_code,
  input  logic            wb_grant,
  output logic            busy,
  output logic [RW-1:0]   dst,
  output logic [RW-1:0]   src1,
  output logic [RW-1:0]   src2,
  output logic            rdy1,
  output logic            rdy2,
  output logic [TAGW-1:0] tag,
  output logic            read_fire,
  output logic            done_fire,
  output logic            wb_pending
);
  phase_e         ph;
  logic [UCW-1:0] q1, q2;
  logic [LATW-1:0] cnt;

  assign busy       = (ph != PH_IDLE);
  assign read_fire  = (ph == PH_WAIT_OPS) && rdy1 && rdy2;
  assign done_fire  = (ph == PH_EXEC) && (cnt == LATW'(1));
  assign wb_pending = (ph == PH_WAIT_WB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      dst  <= '0;
      src1 <= '0;
      src2 <= '0;
      tag  <= '0;
      q1   <= '0;
      q2   <= '0;
      rdy1 <= 1'b0;
      rdy2 <= 1'b0;
      cnt  <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (issue_en) begin
            ph   <= PH_WAIT_OPS;
            dst  <= iss_dst;
            src1 <= iss_src1;
            src2 <= iss_src2;
            tag  <= iss_tag;
            q1   <= iss_q1;
            q2   <= iss_q2;
            rdy1 <= (iss_q1 == '0);
            rdy2 <= (iss_q2 == '0);
          end
        end
        PH_WAIT_OPS: begin
          if (read_fire) begin
            ph   <= PH_EXEC;
            cnt  <= LATW'(LATENCY);
            rdy1 <= 1'b0;
            rdy2 <= 1'b0;
          end else begin
            if (wb_any && !rdy1 && (q1 == wb_code)) begin
              rdy1 <= 1'b1;
              q1   <= '0;
            end
            if (wb_any && !rdy2 && (q2 == wb_code)) begin
              rdy2 <= 1'b1;
              q2   <= '0;
            end
          end
        end
        PH_EXEC: begin
          cnt <= cnt - LATW'(1);
          if (cnt == LATW'(1)) ph <= PH_WAIT_WB;
        end
        PH_WAIT_WB: begin
          if (wb_grant) ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R1: the controller only hands an instruction to an idle unit
  p_issue_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> (ph == PH_IDLE));

  // R2: readiness flags are consumed by the operand read
  p_ready_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    read_fire |=> (!rdy1 && !rdy2));

  // R5: an executing unit always has cycles left to count
  p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_EXEC) |-> (cnt != '0));

  // R6: a write grant only reaches a unit holding a finished result
  p_grant_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_grant |-> (ph == PH_WAIT_WB));
endmodule

// File: rtl/sb_scoreboard_ctrl.sv
module sb_scoreboard_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_MUL = 2,
  parameter int NREG    = 16,
  parameter int TAGW    = 4,
  parameter int CYCW    = 16,
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40,
  localparam int NU     = NUM_MUL + 3,
  localparam int RW     = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         in_op,
  input  logic [RW-1:0]      in_dst,
  input  logic [RW-1:0]      in_src1,
  input  logic [RW-1:0]      in_src2,
  output logic               in_ready,
  output logic               iss_fire,
  output logic [TAGW-1:0]    iss_tag,
  output logic [CYCW-1:0]    cycle_no,
  output logic [NU-1:0]      rd_fire,
  output logic [NU-1:0]      done_fire,
  output logic [NU-1:0]      wb_fire,
  output logic [NU*TAGW-1:0] unit_tags
);
  localparam int UCW  = $clog2(NU + 1);
  localparam int LATW = lat_bits(LAT_INT, LAT_MUL, LAT_ADD, LAT_DIV);
  localparam int ADD_U = NUM_MUL + 1;
  localparam int DIV_U = NUM_MUL + 2;

  // per-register result owner (0 = none)
  logic [UCW-1:0] owner [NREG];

  // unit status as seen by the rest of the controller
  logic [NU-1:0]   u_busy, u_rdy1, u_rdy2, u_wbp;
  logic [RW-1:0]   u_dst  [NU];
  logic [RW-1:0]   u_src1 [NU];
  logic [RW-1:0]   u_src2 [NU];
  logic [TAGW-1:0] u_tag  [NU];

  // named internal events
  logic [$clog2(NU)-1:0] tgt;
  logic                  tgt_free;
  logic [UCW-1:0]        iss_ucode;
  logic [UCW-1:0]        iss_q1, iss_q2;
  logic [NU-1:0]         war_block;
  logic [NU-1:0]         wb_req;
  logic [UCW-1:0]        wb_code;
  logic                  wb_any;
  logic [RW-1:0]         wb_dst;
  logic [TAGW-1:0]       next_tag;

  // ---------------- issue: pick the unit for this class
  always_comb begin
    tgt      = '0;
    tgt_free = 1'b0;
    case (opclass_e'(in_op))
      OPC_INT: begin
        tgt      = '0;
        tgt_free = !u_busy[0];
      end
      OPC_MUL: begin
        for (int m = NUM_MUL; m >= 1; m--) begin
          if (!u_busy[m]) begin
            tgt      = ($clog2(NU))'(m);
            tgt_free = 1'b1;
          end
        end
      end
      OPC_ADD: begin
        tgt      = ($clog2(NU))'(ADD_U);
        tgt_free = !u_busy[ADD_U];
      end
      default: begin
        tgt      = ($clog2(NU))'(DIV_U);
        tgt_free = !u_busy[DIV_U];
      end
    endcase
  end

  assign iss_ucode = UCW'(tgt) + UCW'(1);
  assign in_ready  = tgt_free && (owner[in_dst] == '0);
  assign iss_fire  = in_valid && in_ready;
  assign iss_tag   = next_tag;

  // a producer writing in the issue cycle is treated as already done
  always_comb begin
    iss_q1 = owner[in_src1];
    iss_q2 = owner[in_src2];
    if (wb_any && iss_q1 == wb_code) iss_q1 = '0;
    if (wb_any && iss_q2 == wb_code) iss_q2 = '0;
  end

  // ---------------- unit slots
  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int ULAT = unit_latency(u, NUM_MUL, LAT_INT, LAT_MUL, LAT_ADD, LAT_DIV);
    sb_unit_slot #(
      .RW(RW), .UCW(UCW), .TAGW(TAGW), .LATW(LATW), .LATENCY(ULAT)
    ) slot_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_en   (iss_fire && (tgt == ($clog2(NU))'(u))),
      .iss_dst    (in_dst),
      .iss_src1   (in_src1),
      .iss_src2   (in_src2),
      .iss_q1     (iss_q1),
      .iss_q2     (iss_q2),
      .iss_tag    (next_tag),
      .wb_any     (wb_any),
      .wb_code    (wb_code),
      .wb_grant   (wb_fire[u]),
      .busy       (u_busy[u]),
      .dst        (u_dst[u]),
      .src1       (u_src1[u]),
      .src2       (u_src2[u]),
      .rdy1       (u_rdy1[u]),
      .rdy2       (u_rdy2[u]),
      .tag        (u_tag[u]),
      .read_fire  (rd_fire[u]),
      .done_fire  (done_fire[u]),
      .wb_pending (u_wbp[u])
    );
    assign unit_tags[u*TAGW +: TAGW] = u_tag[u];
  end

  // ---------------- write-back: WAR hold, then fixed priority
  always_comb begin
    war_block = '0;
    for (int u = 0; u < NU; u++) begin
      for (int f = 0; f < NU; f++) begin
        if (f != u &&
            ((u_rdy1[f] && u_src1[f] == u_dst[u]) ||
             (u_rdy2[f] && u_src2[f] == u_dst[u])))
          war_block[u] = 1'b1;
      end
    end
  end

  assign wb_req = u_wbp & ~war_block;

  sb_wb_arbiter #(.N(NU), .CW(UCW)) arb_i (
    .req   (wb_req),
    .grant (wb_fire),
    .code  (wb_code)
  );

  assign wb_any = |wb_fire;

  always_comb begin
    wb_dst = '0;
    for (int u = 0; u < NU; u++) if (wb_fire[u]) wb_dst = u_dst[u];
  end

  // ---------------- owner table, tag and cycle counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) owner[r] <= '0;
      next_tag <= '0;
      cycle_no <= CYCW'(1);
    end else begin
      cycle_no <= cycle_no + CYCW'(1);
      if (wb_any) owner[wb_dst] <= '0;
      if (iss_fire) begin
        owner[in_dst] <= iss_ucode;
        next_tag      <= next_tag + TAGW'(1);
      end
    end
  end

  // R3: in-flight destinations are pairwise distinct
  for (genvar a = 0; a < NU; a++) begin : g_waw_a
    for (genvar b = a + 1; b < NU; b++) begin : g_waw_b
      p_waw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (u_busy[a] && u_busy[b]) |-> (u_dst[a] != u_dst[b]));
    end
  end

  // R4: issue records the owning unit for the destination
  p_owner_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> (owner[$past(in_dst)] == $past(iss_ucode)));

  // R6: the arbiter never grants a unit held by an unread source
  for (genvar u = 0; u < NU; u++) begin : g_war_chk
    p_war_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_fire[u] |-> !war_block[u]);
  end

  // R8: a single write per cycle
  p_wb_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_fire));
endmodule

// File: tb/sb_scoreboard_ctrl_tb_top.sv
module sb_scoreboard_ctrl_tb_top;
  localparam int NU   = 5;
  localparam int TAGW = 4;
  localparam int MAXB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = '0;
  logic [3:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic        in_ready, iss_fire;
  logic [3:0]  iss_tag;
  logic [15:0] cycle_no;
  logic [NU-1:0] rd_fire, done_fire, wb_fire;
  logic [NU*TAGW-1:0] unit_tags;

  always #10 clk = ~clk;

  sb_scoreboard_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_ready(in_ready), .iss_fire(iss_fire), .iss_tag(iss_tag),
    .cycle_no(cycle_no), .rd_fire(rd_fire), .done_fire(done_fire),
    .wb_fire(wb_fire), .unit_tags(unit_tags)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int wd       = 0;

  // batch record, indexed by program order
  int b_op [MAXB], b_dst [MAXB], b_s1 [MAXB], b_s2 [MAXB];
  int c_iss[MAXB], c_rd [MAXB], c_dn [MAXB], c_wb [MAXB], c_unit[MAXB];
  int b_n = 0, base_tag = 0, issued_total = 0, wb_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lat_of(input int op);
    case (op)
      0: return 1;
      1: return 10;
      2: return 2;
      default: return 40;
    endcase
  endfunction

  function automatic int last_writer(input int i, input int r);
    for (int j = i - 1; j >= 0; j--) if (b_dst[j] == r) return j;
    return -1;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // event monitor, mid-cycle
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (iss_fire) c_iss[(int'(iss_tag) - base_tag) & 15] = int'(cycle_no);
      for (int u = 0; u < NU; u++) begin
        int ix;
        ix = (int'(unit_tags[u*TAGW +: TAGW]) - base_tag) & 15;
        if (rd_fire[u]) begin
          c_rd[ix] = int'(cycle_no);
          c_unit[ix] = u;
        end
        if (done_fire[u]) c_dn[ix] = int'(cycle_no);
        if (wb_fire[u]) begin
          c_wb[ix] = int'(cycle_no);
          wb_seen++;
        end
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic start_batch();
    base_tag = issued_total & 15;
    b_n = 0;
    wb_seen = 0;
    for (int i = 0; i < MAXB; i++) begin
      c_iss[i] = -1; c_rd[i] = -1; c_dn[i] = -1; c_wb[i] = -1; c_unit[i] = -1;
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input int op, input int d, input int s1, input int s2, input int earliest);
    bit ok;
    b_op[b_n] = op; b_dst[b_n] = d; b_s1[b_n] = s1; b_s2[b_n] = s2;
    b_n++;
    while (int'(cycle_no) < earliest) @(negedge clk);
    in_valid = 1'b1;
    in_op    = 2'(op);
    in_dst   = 4'(d);
    in_src1  = 4'(s1);
    in_src2  = 4'(s2);
    ok = 1'b0;
    while (!ok) begin
      #5;
      ok = in_ready;
      if (ok) chk(int'(iss_tag) == (issued_total & 15), "R9 tag order",
                  int'(iss_tag), issued_total & 15);
      @(negedge clk);
    end
    issued_total++;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (wb_seen < b_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_batch();
    for (int i = 0; i < b_n; i++) begin
      int exp_rd, wmin, j;
      if (i > 0) chk(c_iss[i] > c_iss[i-1], "R1 in-order issue", c_iss[i], c_iss[i-1] + 1);
      exp_rd = c_iss[i] + 1;
      j = last_writer(i, b_s1[i]);
      if (j >= 0) exp_rd = imax(exp_rd, c_wb[j] + 1);
      j = last_writer(i, b_s2[i]);
      if (j >= 0) exp_rd = imax(exp_rd, c_wb[j] + 1);
      chk(c_rd[i] == exp_rd, "R2 R7 operand read cycle", c_rd[i], exp_rd);
      chk(c_dn[i] == c_rd[i] + lat_of(b_op[i]), "R5 execution latency",
          c_dn[i], c_rd[i] + lat_of(b_op[i]));
      wmin = c_dn[i] + 1;
      for (int k = 0; k < i; k++)
        if (b_s1[k] == b_dst[i] || b_s2[k] == b_dst[i]) wmin = imax(wmin, c_rd[k] + 1);
      chk(c_wb[i] >= wmin, "R6 write after completion and older reads", c_wb[i], wmin);
      j = last_writer(i, b_dst[i]);
      if (j >= 0) chk(c_iss[i] >= c_wb[j] + 1, "R3 destination stall", c_iss[i], c_wb[j] + 1);
      for (int k = 0; k < i; k++)
        chk(c_wb[i] != c_wb[k], "R8 single write per cycle", c_wb[i], -1);
    end
  endtask

  initial begin
    int t;
    void'($urandom(32'h5C0B_0A2D));
    repeat (3) @(negedge clk);
    #5;
    // R10 reset state
    chk(in_ready == 1'b1, "R10 ready in reset", int'(in_ready), 1);
    chk(rd_fire == '0 && done_fire == '0 && wb_fire == '0, "R10 no events", int'(wb_fire), 0);
    chk(cycle_no == 16'd1, "R10 cycle number", int'(cycle_no), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: classic six-instruction program
    start_batch();
    send(0, 6, 15, 15, 0);
    send(0, 2, 15, 15, 0);
    send(1, 0, 2, 4, 0);
    send(2, 8, 6, 2, 0);
    send(3, 10, 0, 6, 0);
    send(2, 6, 8, 2, 0);
    drain();
    begin
      int ei [6] = '{1, 5, 6, 7, 8, 13};
      int er [6] = '{2, 6, 9, 9, 21, 14};
      int ed [6] = '{3, 7, 19, 11, 61, 16};
      int ew [6] = '{4, 8, 20, 12, 62, 22};
      int eu [6] = '{0, 0, 1, 3, 4, 3};
      for (int i = 0; i < 6; i++) begin
        chk(c_iss[i] == ei[i], "R1 issue cycle", c_iss[i], ei[i]);
        chk(c_rd[i]  == er[i], "R2 read cycle", c_rd[i], er[i]);
        chk(c_dn[i]  == ed[i], "R5 complete cycle", c_dn[i], ed[i]);
        chk(c_wb[i]  == ew[i], "R6 write cycle", c_wb[i], ew[i]);
        chk(c_unit[i] == eu[i], "R9 unit choice", c_unit[i], eu[i]);
      end
    end
    check_batch();

    // directed: integer and adder finish together, integer writes first
    start_batch();
    t = int'(cycle_no);
    send(2, 1, 14, 14, 0);
    send(0, 2, 14, 14, 0);
    drain();
    chk(c_dn[0] == t + 3 && c_dn[1] == t + 3, "R8 same completion", c_dn[1], t + 3);
    chk(c_wb[1] == t + 4, "R8 integer unit wins", c_wb[1], t + 4);
    chk(c_wb[0] == t + 5, "R8 adder waits", c_wb[0], t + 5);
    check_batch();

    // directed: issue in the same cycle as the source's write
    start_batch();
    t = int'(cycle_no);
    send(0, 5, 14, 14, 0);
    send(2, 7, 5, 0, t + 3);
    drain();
    chk(c_wb[0] == t + 3 && c_iss[1] == t + 3, "R4 issue meets write", c_iss[1], t + 3);
    chk(c_rd[1] == t + 4, "R4 source ready at issue", c_rd[1], t + 4);
    check_batch();

    // directed: destination stall behind a divide
    start_batch();
    t = int'(cycle_no);
    send(3, 3, 1, 1, 0);
    send(2, 3, 2, 2, 0);
    drain();
    chk(c_wb[0] == t + 42, "R5 divide write", c_wb[0], t + 42);
    chk(c_iss[1] == t + 43, "R3 issue after owner write", c_iss[1], t + 43);
    chk(c_rd[1] == t + 44, "R2 read after issue", c_rd[1], t + 44);
    check_batch();

    // random programs over eight registers
    for (int bt = 0; bt < 10; bt++) begin
      start_batch();
      for (int i = 0; i < 12; i++) begin
        int r, op;
        r = int'($urandom % 20);
        op = (r < 6) ? 0 : (r < 11) ? 1 : (r < 18) ? 2 : 3;
        send(op, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), 0);
      end
      drain();
      check_batch();
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule